// File: doc/BRIEF.md
# CAN Transmit Pin Test Multiplexer

This block sits between a CAN protocol core and the transmit pad. It chooses which of four sources drives the pin, using a two-bit selection field from a test register. The default source is the core's serial bitstream. The other three are for physical-layer bring-up:

- a copy of the core's sample-point strobe, so bit timing can be observed on a scope;
- a constant dominant (low) level;
- a constant recessive (high) level.

The receive pad is brought back as a status bit, so software can compare the level it forces on the transmit pin with what the bus actually shows.

The three test sources break normal protocol operation. Hardware therefore forces the serial-data source whenever any of the following is active, whatever the select field holds:

- a message transfer;
- internal loopback;
- silent (listen-only) operation;
- buffer-only test operation.

The transmit pin comes from a register, so the pad never sees glitches from the selection logic. The receive status passes through a two-stage synchronizer before software can read it.

Top module: `cantx_pin_test`

## Requirements
- R1: While `rst` is high at a rising clock edge, `tx_pin` reads 1 (recessive) and `rx_status` reads 1 after that edge.
- R2: With no override active and `pin_sel` = 2'b00 (serial data), `tx_pin` after a rising edge equals `core_tx_bit` sampled at that edge.
- R3: With no override active and `pin_sel` = 2'b01 (sample point), `tx_pin` after a rising edge equals `sample_strobe` sampled at that edge, so a one-cycle strobe gives a one-cycle pin pulse delayed by one register.
- R4: With no override active and `pin_sel` = 2'b10 (constant dominant), `tx_pin` after the edge is 0, whatever `core_tx_bit` and `sample_strobe` are.
- R5: With no override active and `pin_sel` = 2'b11 (constant recessive), `tx_pin` after the edge is 1, whatever `core_tx_bit` and `sample_strobe` are.
- R6: When any of `xfer_active`, `loopback_en`, `silent_en` or `bufonly_en` is 1 at a rising edge, `tx_pin` after that edge equals `core_tx_bit`, whatever `pin_sel` holds.
- R7: `rx_status` equals the level of `rx_pin` sampled two rising edges earlier, once two edges have passed since reset released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_tx_bit | input | 1 | Serial bit from the protocol core |
| sample_strobe | input | 1 | One-cycle pulse at each bit's sample point |
| pin_sel | input | 2 | Test-register source select (00 serial, 01 sample point, 10 dominant, 11 recessive) |
| xfer_active | input | 1 | Message transfer in progress |
| loopback_en | input | 1 | Loopback test mode enabled |
| silent_en | input | 1 | Silent test mode enabled |
| bufonly_en | input | 1 | Buffer-only test mode enabled |
| rx_pin | input | 1 | Raw receive pad level |
| tx_pin | output | 1 | Transmit pad level |
| rx_status | output | 1 | Synchronized receive level for software |

## Verification
The hardest case to reach is a non-default select value that is held steady while one of the four override sources toggles on and off. Only then does the forced return to serial data show, and only when the core bit differs from the constant the select would otherwise produce. The stimulus draws each override enable with low probability and keeps the select field random, so override windows cut across every select value. Directed segments add the rest:
- a dominant select with the core bit held at 1 while each enable is pulsed alone;
- isolated one-cycle sample strobes under the sample-point select, to show the pulse width on the pin.

// File: rtl/cantx_pkg.sv
package cantx_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_SERIAL    = 2'b00,
        SRC_SAMPLE    = 2'b01,
        SRC_DOMINANT  = 2'b10,
        SRC_RECESSIVE = 2'b11
    } tx_src_e;

    localparam logic LVL_DOMINANT  = 1'b0;
    localparam logic LVL_RECESSIVE = 1'b1;

    typedef struct packed {
        logic xfer;
        logic loopback;
        logic silent;
        logic bufonly;
    } guard_t;

    typedef struct packed {
        logic data;
        logic strobe;
    } core_sig_t;

    function automatic logic guard_any(input guard_t g);
        return g.xfer | g.loopback | g.silent | g.bufonly;
    endfunction

    function automatic logic src_level(input tx_src_e src, input core_sig_t c);
        logic lvl;
        case (src)
            SRC_SERIAL:    lvl = c.data;
            SRC_SAMPLE:    lvl = c.strobe;
            SRC_DOMINANT:  lvl = LVL_DOMINANT;
            default:       lvl = LVL_RECESSIVE;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/cantx_src_arbiter.sv
module cantx_src_arbiter
    import cantx_pkg::*;
(
    input  logic [SEL_W-1:0] sel_raw,
    input  guard_t           guard,
    output tx_src_e          src_eff
);
    always_comb begin
        if (guard_any(guard)) src_eff = SRC_SERIAL;
        else                  src_eff = tx_src_e'(sel_raw);
    end
endmodule

// File: rtl/cantx_pin_mux.sv
module cantx_pin_mux
    import cantx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tx_src_e   src,
    input  core_sig_t core,
    output logic      pin_q
);
    logic pin_d;

    always_comb pin_d = src_level(src, core);

    always_ff @(posedge clk) begin
        if (rst) pin_q <= LVL_RECESSIVE;
        else     pin_q <= pin_d;
    end
endmodule

// File: rtl/cantx_rx_sync.sv
module cantx_rx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RST_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_LVL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_LVL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cantx_pin_test.sv
module cantx_pin_test
    import cantx_pkg::*;
#(
    parameter int RX_SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_tx_bit,
    input  logic             sample_strobe,
    input  logic [SEL_W-1:0] pin_sel,
    input  logic             xfer_active,
    input  logic             loopback_en,
    input  logic             silent_en,
    input  logic             bufonly_en,
    input  logic             rx_pin,
    output logic             tx_pin,
    output logic             rx_status
);
    guard_t    guard;
    core_sig_t core;
    tx_src_e   src_eff;

    always_comb begin
        guard.xfer     = xfer_active;
        guard.loopback = loopback_en;
        guard.silent   = silent_en;
        guard.bufonly  = bufonly_en;
        core.data      = core_tx_bit;
        core.strobe    = sample_strobe;
    end

    cantx_src_arbiter u_arb (
        .sel_raw (pin_sel),
        .guard   (guard),
        .src_eff (src_eff)
    );

    cantx_pin_mux u_mux (
        .clk   (clk),
        .rst   (rst),
        .src   (src_eff),
        .core  (core),
        .pin_q (tx_pin)
    );

    cantx_rx_sync #(
        .STAGES  (RX_SYNC_STAGES),
        .RST_LVL (LVL_RECESSIVE)
    ) u_rxs (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_pin),
        .q_sync  (rx_status)
    );
endmodule

// File: rtl/cantx_pin_test_chk.sv
module cantx_pin_test_chk (
    input logic       clk,
    input logic       rst,
    input logic       core_tx_bit,
    input logic       sample_strobe,
    input logic [1:0] pin_sel,
    input logic       xfer_active,
    input logic       loopback_en,
    input logic       silent_en,
    input logic       bufonly_en,
    input logic       rx_pin,
    input logic       tx_pin,
    input logic       rx_status
);
    logic       ovr;
    logic [1:0] since_rst;

    assign ovr = xfer_active | loopback_en | silent_en | bufonly_en;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (tx_pin && rx_status));

    // R2
    serial_path_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovr && pin_sel == 2'b00) |=> (tx_pin == $past(core_tx_bit)));

    // R3
    strobe_path_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovr && pin_sel == 2'b01) |=> (tx_pin == $past(sample_strobe)));

    // R4
    dominant_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovr && pin_sel == 2'b10) |=> !tx_pin);

    // R5
    recessive_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovr && pin_sel == 2'b11) |=> tx_pin);

    // R6
    guard_force_chk: assert property (@(posedge clk) disable iff (rst)
        ovr |=> (tx_pin == $past(core_tx_bit)));

    // R7
    rx_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (rx_status == $past(rx_pin, 2)));
endmodule

bind cantx_pin_test cantx_pin_test_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .core_tx_bit   (core_tx_bit),
    .sample_strobe (sample_strobe),
    .pin_sel       (pin_sel),
    .xfer_active   (xfer_active),
    .loopback_en   (loopback_en),
    .silent_en     (silent_en),
    .bufonly_en    (bufonly_en),
    .rx_pin        (rx_pin),
    .tx_pin        (tx_pin),
    .rx_status     (rx_status)
);

// File: tb/cantx_pin_test_bench.sv
`timescale 1ns/1ps
module cantx_pin_test_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       core_tx_bit = 1'b1;
    logic       sample_strobe = 1'b0;
    logic [1:0] pin_sel = 2'b00;
    logic       xfer_active = 1'b0;
    logic       loopback_en = 1'b0;
    logic       silent_en = 1'b0;
    logic       bufonly_en = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_pin;
    logic       rx_status;

    int n_vec = 0;
    int n_bad = 0;

    // Bench model state
    logic exp_tx;
    logic m1, m2;
    logic last_rx;
    string exp_tag;

    always #2 clk = ~clk;

    cantx_pin_test u_cantx_pin_test (
        .clk           (clk),
        .rst           (rst),
        .core_tx_bit   (core_tx_bit),
        .sample_strobe (sample_strobe),
        .pin_sel       (pin_sel),
        .xfer_active   (xfer_active),
        .loopback_en   (loopback_en),
        .silent_en     (silent_en),
        .bufonly_en    (bufonly_en),
        .rx_pin        (rx_pin),
        .tx_pin        (tx_pin),
        .rx_status     (rx_status)
    );

    function automatic logic model_tx(input logic [1:0] sel, input logic any_ovr,
                                      input logic d, input logic s);
        if (any_ovr) return d;
        case (sel)
            2'b00:   return d;
            2'b01:   return s;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic string model_tag(input logic [1:0] sel, input logic any_ovr);
        if (any_ovr) return "R6";
        case (sel)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, expv);
        end
    endtask

    // Called at a negedge: check outputs from the previous drive, then drive new inputs.
    task automatic step(input logic d, input logic s, input logic [1:0] sel,
                        input logic xf, input logic lb, input logic si,
                        input logic bo, input logic rx);
        @(negedge clk);
        m2 = m1;
        m1 = last_rx;
        check(exp_tag, tx_pin, exp_tx);
        check("R7", rx_status, m2);
        core_tx_bit   = d;
        sample_strobe = s;
        pin_sel       = sel;
        xfer_active   = xf;
        loopback_en   = lb;
        silent_en     = si;
        bufonly_en    = bo;
        rx_pin        = rx;
        exp_tx  = model_tx(sel, xf | lb | si | bo, d, s);
        exp_tag = model_tag(sel, xf | lb | si | bo);
        last_rx = rx;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));

        // R1: reset with inputs that would otherwise pull the outputs low
        pin_sel = 2'b10;
        rx_pin  = 1'b0;
        core_tx_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", tx_pin, 1'b1);
        check("R1", rx_status, 1'b1);

        // release reset; the model starts from the reset values
        rst     = 1'b0;
        m1      = 1'b1;
        m2      = 1'b1;
        pin_sel = 2'b00;
        core_tx_bit = 1'b1;
        rx_pin  = 1'b0;
        last_rx = 1'b0;
        exp_tx  = 1'b1;
        exp_tag = "R2";

        // R4 and R6: dominant select held, core bit 1, each enable pulsed alone
        for (int k = 0; k < 4; k++) begin
            step(1, 0, 2'b10, 0, 0, 0, 0, 1);
            step(1, 0, 2'b10, k == 0, k == 1, k == 2, k == 3, 0);
            step(1, 0, 2'b10, 0, 0, 0, 0, 1);
        end

        // R5: recessive select with core bit 0
        step(0, 1, 2'b11, 0, 0, 0, 0, 0);
        step(0, 0, 2'b11, 0, 0, 0, 0, 1);
        step(0, 0, 2'b11, 1, 0, 0, 0, 1);

        // R3: isolated one-cycle sample strobes
        for (int k = 0; k < 6; k++) begin
            step(k[0], 1, 2'b01, 0, 0, 0, 0, k[1]);
            step(k[0], 0, 2'b01, 0, 0, 0, 0, k[1]);
            step(k[0], 0, 2'b01, 0, 0, 0, 0, k[0]);
        end

        // R2: serial data pattern
        for (int k = 0; k < 8; k++)
            step(k[0] ^ k[2], k[1], 2'b00, 0, 0, 0, 0, k[1]);

        // R2..R7: random mix, each enable about one cycle in eight
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] sel;
            sel = 2'($urandom_range(0, 3));
            step(1'($urandom), 1'($urandom_range(0, 3) == 0), sel,
                 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0),
                 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0),
                 1'($urandom));
        end

        // final check of the last drive
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule